// File: doc/BRIEF.md
# Iterated Permutation Engine with Round Accumulator

This block applies a number of rounds of a 320-bit substitution-permutation round to a state that is loaded in one go, and it runs one round on every clock. The state is held as five 64-bit lanes. Each lane is stored bit-interleaved: one 32-bit word holds the lane's even-numbered bits and a second word holds its odd-numbered bits. While the rounds run, the block also builds a 128-bit accumulator. After each round, four XOR combinations of interleaved words taken from different lanes are folded into it. The accumulator is cleared at the start of every invocation.

A caller presents the state and a round count, then pulses `start`. The caller waits for the one-cycle `done` pulse and reads the final state and the accumulator. Both values stay on the outputs until the next accepted start. A round count outside 1..12 is refused. In that case the block finishes at once, leaves the loaded state untouched and leaves the accumulator at zero.

Top module: `perm_acc_engine`

## Requirements
- R1: A start with a round count N in 1..12 is accepted at a clock edge E. Exactly N rounds then run, one per edge, and `done` is high for exactly one cycle, the cycle that follows edge E+N.
- R2: The state port packs 32-bit word w at bits [32w+31:32w], with w = 2*lane + half. Half 0 holds the lane's even bits, so lane bit 2b is word bit b. Half 1 holds the odd bits, so lane bit 2b+1 is word bit b.
- R3: Each round does three things in order. It adds the round constant to lane 2. It applies a 5-bit substitution across the lanes: x0^=x4, x4^=x3, x2^=x1, then each xi ^= (~x(i+1) & x(i+2)) using the pre-step values with indices taken mod 5, then x1^=x0, x3^=x2, x0^=x4, and x2 is inverted. Last, it updates each lane with lane ^= rotr(lane,a) ^ rotr(lane,b). The rotation pairs are (19,28) for lane 0, (61,38) for lane 1, (1,6) for lane 2, (10,17) for lane 3 and (7,40) for lane 4.
- R4: For N rounds, round i (counting from 0) takes entry 12-N+i from the table 4B,5A,69,78,87,96,A5,B4,C3,D2,E1,F0 (hex). Constant bit j is XORed into bit 2j of lane 2, which is the low byte of word 4. The last round of any run therefore uses F0.
- R5: The accumulator is zero after every accepted start. After each round, with L = even word and H = odd word of the new state, its words change as follows: word 0 ^= L(lane0)^H(lane2), word 1 ^= H(lane0)^L(lane3), word 2 ^= L(lane1)^H(lane3) and word 3 ^= L(lane2)^H(lane1). Accumulator word k sits at bits [32k+31:32k].
- R6: A start with a round count of 0 or above 12 makes `done` high in the cycle after the accepting edge. In that cycle the state output equals the presented state and the accumulator is zero.
- R7: After `done`, the state and accumulator outputs hold their values until the next accepted start, whatever the inputs do.
- R8: A start that arrives while rounds are running is ignored and does not change the result of the running invocation.
- R9: A start presented in the cycle where `done` is high is accepted and begins a new invocation.
- R10: After reset, `done` is low and the state and accumulator outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an invocation; sampled at the rising edge |
| rounds | input | 4 | Round count; valid range 1..12 |
| state_in | input | 320 | State to load, interleaved word packing |
| state_out | output | 320 | Current or final state |
| acc_out | output | 128 | Round accumulator, four 32-bit words |
| done | output | 1 | One-cycle completion pulse |

## Verification
Completion and a new start can fall in the same cycle. When `done` is high the engine is idle, so a start in that cycle is accepted at the very edge that ends the visibility of the previous result. The bench provokes this by checking the finished state and accumulator at the falling edge of the `done` cycle and raising `start` with a new state in that same half-cycle. It then expects the second run to finish N cycles later with a cleared-then-refilled accumulator. A mid-run start is also driven to show that completion timing and results depend only on the invocation that is already in flight.

// File: rtl/perm_acc_pkg.sv
package perm_acc_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = 5;
  localparam int WORDS      = 2 * LANES;
  localparam int ACC_WORDS  = 4;
  localparam int MAX_ROUNDS = 12;
  localparam int CNT_W      = 4;
  localparam int RC_W       = 8;

  typedef logic [WORD_W-1:0]                 word_t;
  typedef logic [WORDS-1:0][WORD_W-1:0]      state_t;
  typedef logic [ACC_WORDS-1:0][WORD_W-1:0]  acc_t;
  typedef logic [LANES-1:0][WORD_W-1:0]      plane_t;

  // 32-bit rotate right
  function automatic word_t rotr(input word_t x, input int unsigned s);
    logic [2*WORD_W-1:0] d;
    d = {x, x} >> (s % WORD_W);
    return d[WORD_W-1:0];
  endfunction

  // per-lane rotation amounts of the diffusion step
  function automatic int unsigned rot_a(input int unsigned lane);
    case (lane)
      0: return 19; 1: return 61; 2: return 1; 3: return 10; default: return 7;
    endcase
  endfunction

  function automatic int unsigned rot_b(input int unsigned lane);
    case (lane)
      0: return 28; 1: return 38; 2: return 6; 3: return 17; default: return 40;
    endcase
  endfunction

  // 64-bit rotate right on an interleaved pair; returns {odd', even'}
  function automatic logic [2*WORD_W-1:0] rot_pair(input word_t ev, input word_t od,
                                                   input int unsigned amt);
    int unsigned k;
    k = amt / 2;
    if (amt % 2 == 0) return {rotr(od, k), rotr(ev, k)};
    else              return {rotr(ev, k + 1), rotr(od, k)};
  endfunction

  // 5-input bitsliced substitution on one half-plane
  function automatic plane_t sbox_plane(input plane_t x);
    plane_t y, t;
    y = x;
    y[0] = y[0] ^ y[4];
    y[4] = y[4] ^ y[3];
    y[2] = y[2] ^ y[1];
    for (int i = 0; i < LANES; i++)
      t[i] = ~y[(i+1) % LANES] & y[(i+2) % LANES];
    for (int i = 0; i < LANES; i++)
      y[i] = y[i] ^ t[i];
    y[1] = y[1] ^ y[0];
    y[3] = y[3] ^ y[2];
    y[0] = y[0] ^ y[4];
    y[2] = ~y[2];
    return y;
  endfunction

  // constant for a countdown value cnt (last round cnt=0)
  function automatic logic [RC_W-1:0] round_const(input logic [CNT_W-1:0] cnt);
    logic [3:0] up;
    up = 4'hF - cnt;
    return {up, cnt};
  endfunction

  // accumulator update from the state produced by a round
  function automatic acc_t fold(input state_t s, input acc_t a);
    acc_t r;
    r[0] = a[0] ^ s[0] ^ s[5];
    r[1] = a[1] ^ s[1] ^ s[6];
    r[2] = a[2] ^ s[2] ^ s[7];
    r[3] = a[3] ^ s[4] ^ s[3];
    return r;
  endfunction
endpackage

// File: rtl/perm_round_step.sv
module perm_round_step
  import perm_acc_pkg::*;
(
  input  state_t          st_i,
  input  logic [RC_W-1:0] rc_i,
  output state_t          st_o
);
  plane_t ev_in, od_in, ev_sb, od_sb;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      ev_in[l] = st_i[2*l];
      od_in[l] = st_i[2*l+1];
    end
    ev_in[2] = ev_in[2] ^ {{(WORD_W-RC_W){1'b0}}, rc_i};
  end

  assign ev_sb = sbox_plane(ev_in);
  assign od_sb = sbox_plane(od_in);

  for (genvar g = 0; g < LANES; g++) begin : g_diffuse
    localparam int unsigned RA = rot_a(g);
    localparam int unsigned RB = rot_b(g);
    logic [2*WORD_W-1:0] ra, rb;
    assign ra = rot_pair(ev_sb[g], od_sb[g], RA);
    assign rb = rot_pair(ev_sb[g], od_sb[g], RB);
    assign st_o[2*g]   = ev_sb[g] ^ ra[WORD_W-1:0] ^ rb[WORD_W-1:0];
    assign st_o[2*g+1] = od_sb[g] ^ ra[2*WORD_W-1:WORD_W] ^ rb[2*WORD_W-1:WORD_W];
  end
endmodule

// File: rtl/acc_fold.sv
module acc_fold
  import perm_acc_pkg::*;
(
  input  state_t st_i,
  input  acc_t   acc_i,
  output acc_t   acc_o
);
  assign acc_o = fold(st_i, acc_i);
endmodule

// File: rtl/perm_seq_ctrl.sv
module perm_seq_ctrl
  import perm_acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] rounds,
  output logic             load,
  output logic             step,
  output logic             bad_count,
  output logic [RC_W-1:0]  rc,
  output logic             done
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             count_ok;

  assign count_ok  = (rounds != '0) && (rounds <= CNT_W'(MAX_ROUNDS));
  assign load      = start && !busy_q;
  assign bad_count = load && !count_ok;
  assign step      = busy_q;
  assign rc        = round_const(cnt_q);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        if (count_ok) begin
          busy_q <= 1'b1;
          cnt_q  <= rounds - 1'b1;
        end else begin
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R1: done is a single-cycle pulse unless a new start follows
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start |=> !done_q);
  // R1: countdown stays inside the constant table
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q < CNT_W'(MAX_ROUNDS));
  // R8: a start while busy does not disturb the countdown
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/perm_acc_engine.sv
module perm_acc_engine
  import perm_acc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CNT_W-1:0]            rounds,
  input  logic [WORDS*WORD_W-1:0]     state_in,
  output logic [WORDS*WORD_W-1:0]     state_out,
  output logic [ACC_WORDS*WORD_W-1:0] acc_out,
  output logic                        done
);
  logic            load, step, bad_count;
  logic [RC_W-1:0] rc;
  state_t          st_q, st_next;
  acc_t            acc_q, acc_next;

  perm_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .rounds(rounds),
    .load(load), .step(step), .bad_count(bad_count), .rc(rc), .done(done)
  );

  perm_round_step u_round (.st_i(st_q), .rc_i(rc), .st_o(st_next));

  acc_fold u_fold (.st_i(st_next), .acc_i(acc_q), .acc_o(acc_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      acc_q <= '0;
    end else if (load) begin
      st_q  <= state_t'(state_in);
      acc_q <= '0;
    end else if (step) begin
      st_q  <= st_next;
      acc_q <= acc_next;
    end
  end

  assign state_out = st_q;
  assign acc_out   = acc_q;

  // R5: accumulator cleared by every accepted start
  a_r5_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> acc_out == '0);
  // R6: refused count finishes at once with the state untouched
  a_r6_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
    bad_count |=> done && state_out == $past(state_in) && acc_out == '0);
  // R7: outputs hold while idle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !load |=> $stable(state_out) && $stable(acc_out));
endmodule

// File: tb/tb_perm_acc_engine.sv
module tb_perm_acc_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   rounds = '0;
  logic [319:0] state_in = '0;
  logic [319:0] state_out;
  logic [127:0] acc_out;
  logic         done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  perm_acc_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rounds(rounds),
    .state_in(state_in), .state_out(state_out), .acc_out(acc_out), .done(done)
  );

  task automatic chk(input string req, input logic [319:0] act, input logic [319:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tab(input int k);
    case (k)
      0: return 8'h4B; 1: return 8'h5A; 2: return 8'h69;  3: return 8'h78;
      4: return 8'h87; 5: return 8'h96; 6: return 8'hA5;  7: return 8'hB4;
      8: return 8'hC3; 9: return 8'hD2; 10: return 8'hE1; default: return 8'hF0;
    endcase
  endfunction

  function automatic logic [63:0] rr(input logic [63:0] x, input int s);
    return (x >> s) | (x << (64 - s));
  endfunction

  function automatic logic [31:0] evb(input logic [63:0] v);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = v[2*b];
    return r;
  endfunction

  function automatic logic [31:0] odb(input logic [63:0] v);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = v[2*b+1];
    return r;
  endfunction

  // reference model on plain 64-bit lanes (R2, R3, R4, R5)
  function automatic void model(input logic [319:0] s, input int n,
                                output logic [319:0] so, output logic [127:0] ro);
    logic [4:0][63:0] x;
    logic [63:0] t0, t1, t2, t3, t4;
    logic [7:0] c;
    for (int l = 0; l < 5; l++)
      for (int b = 0; b < 32; b++) begin
        x[l][2*b]   = s[64*l + b];
        x[l][2*b+1] = s[64*l + 32 + b];
      end
    ro = '0;
    for (int i = 0; i < n; i++) begin
      c = tab(12 - n + i);
      for (int j = 0; j < 8; j++) x[2][2*j] = x[2][2*j] ^ c[j];
      x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
      t0 = ~x[0] & x[1]; t1 = ~x[1] & x[2]; t2 = ~x[2] & x[3];
      t3 = ~x[3] & x[4]; t4 = ~x[4] & x[0];
      x[0] ^= t1; x[1] ^= t2; x[2] ^= t3; x[3] ^= t4; x[4] ^= t0;
      x[1] ^= x[0]; x[3] ^= x[2]; x[0] ^= x[4]; x[2] = ~x[2];
      x[0] ^= rr(x[0], 19) ^ rr(x[0], 28);
      x[1] ^= rr(x[1], 61) ^ rr(x[1], 38);
      x[2] ^= rr(x[2], 1)  ^ rr(x[2], 6);
      x[3] ^= rr(x[3], 10) ^ rr(x[3], 17);
      x[4] ^= rr(x[4], 7)  ^ rr(x[4], 40);
      ro[31:0]   ^= evb(x[0]) ^ odb(x[2]);
      ro[63:32]  ^= odb(x[0]) ^ evb(x[3]);
      ro[95:64]  ^= evb(x[1]) ^ odb(x[3]);
      ro[127:96] ^= evb(x[2]) ^ odb(x[1]);
    end
    for (int l = 0; l < 5; l++) begin
      so[64*l +: 32]      = evb(x[l]);
      so[64*l + 32 +: 32] = odb(x[l]);
    end
  endfunction

  function automatic logic [319:0] pattern(input logic [31:0] seed);
    logic [319:0] r;
    for (int w = 0; w < 10; w++) r[32*w +: 32] = (32'h9E3779B9 * (w + 1)) ^ seed;
    return r;
  endfunction

  // call at a falling edge
  task automatic launch(input logic [319:0] s, input int n);
    state_in = s; rounds = 4'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_case(input string req, input logic [319:0] s, input int n);
    logic [319:0] es; logic [127:0] ea; int k, ek;
    bit ok;
    ok = (n >= 1 && n <= 12);
    if (ok) model(s, n, es, ea); else begin es = s; ea = '0; end
    ek = ok ? n : 0;
    @(negedge clk);
    launch(s, n);
    wait_done(k);
    chk({req, " latency"}, 320'(k), 320'(ek));
    chk({req, " state"}, state_out, es);
    chk({req, " acc"}, 320'(acc_out), 320'(ea));
    @(negedge clk);
    chk({req, " done pulse R1"}, 320'(done), 320'(0));
  endtask

  task automatic t_reset;
    chk("R10 reset state", state_out, '0);
    chk("R10 reset acc", 320'(acc_out), '0);
    chk("R10 reset done", 320'(done), '0);
  endtask

  task automatic t_hold;
    logic [319:0] es; logic [127:0] ea; int k;
    model(pattern(32'h0BAD_F00D), 4, es, ea);
    @(negedge clk);
    launch(pattern(32'h0BAD_F00D), 4);
    wait_done(k);
    state_in = ~state_in; rounds = 4'd7;
    repeat (6) @(negedge clk);
    chk("R7 hold state", state_out, es);
    chk("R7 hold acc", 320'(acc_out), 320'(ea));
  endtask

  task automatic t_busy_start;
    logic [319:0] es; logic [127:0] ea; int k;
    model(pattern(32'h1357_9BDF), 8, es, ea);
    @(negedge clk);
    launch(pattern(32'h1357_9BDF), 8);
    @(negedge clk); @(negedge clk);
    state_in = pattern(32'hFFFF_0000); rounds = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(k);
    chk("R8 busy start latency", 320'(k + 3), 320'(8));
    chk("R8 busy start state", state_out, es);
    chk("R8 busy start acc", 320'(acc_out), 320'(ea));
  endtask

  task automatic t_back_to_back;
    logic [319:0] es; logic [127:0] ea; int k;
    @(negedge clk);
    launch(pattern(32'h2222_3333), 3);
    wait_done(k);
    model(pattern(32'h2222_3333), 3, es, ea);
    chk("R9 first state", state_out, es);
    launch(pattern(32'h4444_5555), 2);
    wait_done(k);
    model(pattern(32'h4444_5555), 2, es, ea);
    chk("R9 second latency", 320'(k), 320'(2));
    chk("R9 second state", state_out, es);
    chk("R9 second acc R5", 320'(acc_out), 320'(ea));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R1 R3 R4 R5 one round", pattern(32'h0), 1);
    run_case("R3 R4 R5 zero state", '0, 1);
    run_case("R1 R4 R5 twelve rounds", pattern(32'hA5A5_5A5A), 12);
    run_case("R2 R4 five rounds", pattern(32'h0123_4567), 5);
    run_case("R6 count zero", pattern(32'hDEAD_BEEF), 0);
    run_case("R6 count thirteen", pattern(32'hCAFE_0001), 13);
    run_case("R6 count fifteen", pattern(32'hCAFE_0002), 15);
    t_hold();
    t_busy_start();
    t_back_to_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule